// File: doc/BRIEF.md
# Page Presence Tracker with FIFO Replacement

The tracker models a small, tag-only cache of physical 4 KB pages. On each lookup it receives a physical address and a read/write kind. It then reports, one cycle later, whether the page was already resident. On a miss it does four things:

- counts the miss in the counter for its kind;
- adds a wait-state penalty to a running cycle total;
- evicts the oldest entry of a circular tag ring;
- records the new page as resident.

The tracker stores no data. It only keeps presence state and timing cost.

Configuration inputs set the ring depth, the bus width and the clock multiplier. A flag marks a processor class that has no cache cost. Residency is held in a bitmap indexed by the low bits of the page number. A flush input walks the ring back to empty and raises a busy output while it runs.

Top module: `page_presence_tracker`

## Requirements
- R1: After reset `res_valid` is 0, `busy` is 0, every counter and the penalty total are 0, and every page is absent.
- R2: The page number is `lookup_addr >> 12`. Any two addresses in the same 4 KB page share one presence state. Only the low `MAP_BITS` bits of the page number select the presence bit, so pages that differ only above those bits alias to one entry.
- R3: An accepted lookup raises `res_valid` for exactly the next cycle. `res_hit` then shows the presence bit as it was before the lookup. A miss marks the page present.
- R4: `cfg_cache_sel` sets the ring depth: 0 gives 32 entries, 1 gives 64, 2 gives 128, and 3 to 7 give 256. With depth N, a page stays present through N distinct misses and is gone after the (N+1)-th.
- R5: On a miss the page at the victim position is evicted and its presence is cleared. An empty slot (all-ones tag) evicts nothing. The victim position then advances by one, modulo the ring depth, so pages leave in arrival order.
- R6: Read misses increment `rd_miss_cnt` and write misses increment `wr_miss_cnt`, each by one. Hits change neither counter.
- R7: Every miss adds a penalty to `penalty_total`. The penalty is 512 cycles when `cfg_bus16` is 1 and 384 cycles otherwise, multiplied by `cfg_mult` capped at 2. Hits add nothing.
- R8: `cfg_cache_sel` = 4 or `cfg_legacy_cpu` = 1 forces a depth of 256 and a penalty of zero.
- R9: A `flush` pulse seen while idle clears every presence bit, empties every ring slot and returns the victim position to 0. `busy` is high for exactly 256 cycles starting the cycle after the pulse. Lookups presented while `busy` (or alongside `flush`) are dropped: they produce no result and leave the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_write | input | 1 | 1 = write lookup, 0 = read lookup |
| lookup_addr | input | ADDR_W | Physical address of the lookup |
| cfg_cache_sel | input | 3 | Ring depth / cost setting |
| cfg_bus16 | input | 1 | 1 = narrow 16-bit bus (larger penalty) |
| cfg_mult | input | MULT_W | Clock multiplier, capped at 2 |
| cfg_legacy_cpu | input | 1 | Processor class with no cache cost |
| flush | input | 1 | Start a flush |
| busy | output | 1 | Flush in progress |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup found the page present |
| rd_miss_cnt | output | CNT_W | Read miss count |
| wr_miss_cnt | output | CNT_W | Write miss count |
| penalty_total | output | PEN_W | Accumulated penalty cycles |

## Verification
The bench builds the tracker with `MAP_BITS` = 9, a 512-page bitmap, and keeps the ring maximum at 256. This makes pages twice the largest ring depth reachable, so aliasing above bit 20 of the address can be probed. Every ring depth can also be filled completely without wrapping the bitmap.

With these values, the bench sweeps every depth setting, both bus widths, multipliers 0 to 3 and both processor classes. For each combination it fills the ring exactly, probes the oldest page on both sides of the eviction boundary, and compares the counter and penalty deltas against closed-form products.

// File: rtl/ptrk_pkg.sv
// Shared constants and helpers for the page presence tracker.
// Assumes ring depths are powers of two between 2**RING_LOG_MIN and 2**log_max.
package ptrk_pkg;

    localparam int unsigned RING_LOG_MIN = 5;
    localparam int unsigned PEN_NARROW   = 512;
    localparam int unsigned PEN_WIDE     = 384;
    localparam int unsigned MULT_CAP     = 2;
    localparam logic [2:0]  SEL_NO_COST  = 3'd4;

    // Ring depth exponent chosen by a cache setting and the processor class.
    function automatic int unsigned ring_log2(input logic [2:0] sel,
                                              input logic legacy,
                                              input int unsigned log_max);
        int unsigned lg;
        if (legacy || sel == SEL_NO_COST) begin
            lg = log_max;
        end else begin
            lg = RING_LOG_MIN + int'(sel);
            if (lg > log_max) lg = log_max;
        end
        return lg;
    endfunction

endpackage

// File: rtl/ptrk_cfg.sv
// Configuration decode: turns the setting, bus width, multiplier and
// processor class into a ring index mask and a per-miss penalty.
// Purely combinational; assumes IDX_W equals the largest ring exponent.
module ptrk_cfg
    import ptrk_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned MULT_W = 3,
    parameter int unsigned STEP_W = 11
) (
    input  logic [2:0]        cache_sel,
    input  logic              bus16,
    input  logic [MULT_W-1:0] mult,
    input  logic              legacy,
    output logic [IDX_W-1:0]  ring_mask,
    output logic [STEP_W-1:0] step
);

    logic [IDX_W:0] depth_one_hot;
    int unsigned    lg;
    int unsigned    capped;
    int unsigned    base;

    // Ring mask from the selected depth exponent.
    always_comb begin
        lg            = ring_log2(cache_sel, legacy, IDX_W);
        depth_one_hot = (IDX_W+1)'(1) << lg;
        ring_mask     = IDX_W'(depth_one_hot - (IDX_W+1)'(1));
    end

    // Penalty per miss: bus base cost times the capped multiplier.
    always_comb begin
        capped = (int'(mult) > MULT_CAP) ? MULT_CAP : int'(mult);
        base   = bus16 ? PEN_NARROW : PEN_WIDE;
        if (legacy || cache_sel == SEL_NO_COST) begin
            step = '0;
        end else begin
            step = STEP_W'(base * capped);
        end
    end

endmodule

// File: rtl/ptrk_presence.sv
// Presence bitmap: one bit per tracked page index.
// Clear-all wins over point updates; a point clear and a point set in the
// same cycle are applied in that order. Assumes clr_idx != set_idx when
// both are enabled (the caller guarantees an evicted page is not the new one).
module ptrk_presence #(
    parameter int unsigned MAP_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_all,
    input  logic                clr_en,
    input  logic [MAP_BITS-1:0] clr_idx,
    input  logic                set_en,
    input  logic [MAP_BITS-1:0] set_idx,
    input  logic [MAP_BITS-1:0] rd_idx,
    output logic                present
);

    localparam int unsigned PAGES = 1 << MAP_BITS;

    logic [PAGES-1:0] bits;

    // Maintain the bitmap under reset, flush, eviction and fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (clr_all) begin
            bits <= '0;
        end else begin
            if (clr_en) bits[clr_idx] <= 1'b0;
            if (set_en) bits[set_idx] <= 1'b1;
        end
    end

    // Read port for the current lookup.
    assign present = bits[rd_idx];

    // R3
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en && !clr_all |=> bits[$past(set_idx)]);

    // R9
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (bits == '0));

endmodule

// File: rtl/ptrk_ring.sv
// Circular tag ring with a round-robin victim pointer and a flush walker.
// An all-ones tag marks an empty slot. The flush empties one slot per cycle
// for DEPTH cycles and holds busy high meanwhile; replacement is ignored
// while busy. The mask must describe a power-of-two depth <= DEPTH.
module ptrk_ring #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned TAG_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_start,
    input  logic [IDX_W-1:0] ring_mask,
    input  logic             repl_en,
    input  logic [TAG_W-1:0] new_tag,
    output logic [TAG_W-1:0] victim_tag,
    output logic             victim_valid,
    output logic             busy
);

    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam logic [TAG_W-1:0] EMPTY = '1;
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(DEPTH - 1);

    logic [TAG_W-1:0] slots [DEPTH];
    logic [IDX_W-1:0] victim;
    logic [IDX_W-1:0] fl_cnt;
    logic [IDX_W-1:0] widx;

    assign widx = victim & ring_mask;

    // Control state: flush walker, busy flag and victim pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            fl_cnt <= '0;
            victim <= '0;
        end else if (flush_start) begin
            busy   <= 1'b1;
            fl_cnt <= '0;
            victim <= '0;
        end else if (busy) begin
            fl_cnt <= fl_cnt + 1'b1;
            if (fl_cnt == LAST) busy <= 1'b0;
        end else if (repl_en) begin
            victim <= (victim + 1'b1) & ring_mask;
        end
    end

    // Slot storage: reset fill, flush walk and replacement writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= EMPTY;
        end else if (busy) begin
            slots[fl_cnt] <= EMPTY;
        end else if (repl_en && !flush_start) begin
            slots[widx] <= new_tag;
        end
    end

    // Expose the entry that the next miss would evict.
    assign victim_tag   = slots[widx];
    assign victim_valid = (victim_tag != EMPTY);

    // R9
    flush_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(fl_cnt) == LAST));

    // R5
    slot_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repl_en && !busy && !flush_start |=> (slots[$past(widx)] == $past(new_tag)));

endmodule

// File: rtl/page_presence_tracker.sv
// Page presence tracker: one-cycle lookup of 4 KB page residency with
// FIFO replacement, split miss counters and an accumulated wait penalty.
// Assumes ADDR_W > PAGE_SHIFT + MAP_BITS. Lookups arriving during a flush
// (or alongside the flush request) are dropped.
module page_presence_tracker
    import ptrk_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned PAGE_SHIFT   = 12,
    parameter int unsigned MAP_BITS     = 10,
    parameter int unsigned RING_LOG_MAX = 8,
    parameter int unsigned MULT_W       = 3,
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned PEN_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup_valid,
    input  logic              lookup_write,
    input  logic [ADDR_W-1:0] lookup_addr,
    input  logic [2:0]        cfg_cache_sel,
    input  logic              cfg_bus16,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic              cfg_legacy_cpu,
    input  logic              flush,
    output logic              busy,
    output logic              res_valid,
    output logic              res_hit,
    output logic [CNT_W-1:0]  rd_miss_cnt,
    output logic [CNT_W-1:0]  wr_miss_cnt,
    output logic [PEN_W-1:0]  penalty_total
);

    localparam int unsigned TAG_W  = MAP_BITS + 1;
    localparam int unsigned STEP_W = $clog2(PEN_NARROW * MULT_CAP + 1);

    logic [MAP_BITS-1:0] page_idx;
    logic [TAG_W-1:0]    new_tag;
    logic [TAG_W-1:0]    victim_tag;
    logic                victim_valid;
    logic [RING_LOG_MAX-1:0] ring_mask;
    logic [STEP_W-1:0]   step;
    logic                present;
    logic                accept;
    logic                miss;
    logic                flush_start;
    logic                unused_addr_bits;

    assign page_idx         = lookup_addr[PAGE_SHIFT +: MAP_BITS];
    assign new_tag          = {1'b0, page_idx};
    assign unused_addr_bits = ^{lookup_addr[PAGE_SHIFT-1:0],
                                lookup_addr[ADDR_W-1:PAGE_SHIFT+MAP_BITS]};
    assign flush_start      = flush && !busy;
    assign accept           = lookup_valid && !busy && !flush;
    assign miss             = accept && !present;

    ptrk_cfg #(
        .IDX_W  (RING_LOG_MAX),
        .MULT_W (MULT_W),
        .STEP_W (STEP_W)
    ) u_cfg (
        .cache_sel (cfg_cache_sel),
        .bus16     (cfg_bus16),
        .mult      (cfg_mult),
        .legacy    (cfg_legacy_cpu),
        .ring_mask (ring_mask),
        .step      (step)
    );

    ptrk_presence #(
        .MAP_BITS (MAP_BITS)
    ) u_presence (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (flush_start),
        .clr_en  (miss && victim_valid),
        .clr_idx (victim_tag[MAP_BITS-1:0]),
        .set_en  (miss),
        .set_idx (page_idx),
        .rd_idx  (page_idx),
        .present (present)
    );

    ptrk_ring #(
        .IDX_W (RING_LOG_MAX),
        .TAG_W (TAG_W)
    ) u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_start  (flush_start),
        .ring_mask    (ring_mask),
        .repl_en      (miss),
        .new_tag      (new_tag),
        .victim_tag   (victim_tag),
        .victim_valid (victim_valid),
        .busy         (busy)
    );

    // Register the lookup result for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
        end else begin
            res_valid <= accept;
            res_hit   <= accept && present;
        end
    end

    // Count misses by kind and accumulate the wait penalty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_miss_cnt   <= '0;
            wr_miss_cnt   <= '0;
            penalty_total <= '0;
        end else if (miss) begin
            if (lookup_write) wr_miss_cnt <= wr_miss_cnt + 1'b1;
            else              rd_miss_cnt <= rd_miss_cnt + 1'b1;
            penalty_total <= penalty_total + PEN_W'(step);
        end
    end

    // R9
    no_result_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !res_valid);

    // R7
    hit_no_penalty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_hit |-> (penalty_total == $past(penalty_total)));

    // R6
    read_keeps_wr_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !lookup_write |=> $stable(wr_miss_cnt));

    // R8
    legacy_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cfg_legacy_cpu |=> $stable(penalty_total));

endmodule

// File: tb/page_presence_tracker_test.sv
// Self-checking bench: directed residency/eviction/alias/flush cases, then a
// sweep over every depth setting, bus width, multiplier and processor class.
module page_presence_tracker_test;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned MAP_B  = 9;
    localparam int unsigned MULT_W = 3;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned PEN_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              lookup_valid;
    logic              lookup_write;
    logic [ADDR_W-1:0] lookup_addr;
    logic [2:0]        cfg_cache_sel;
    logic              cfg_bus16;
    logic [MULT_W-1:0] cfg_mult;
    logic              cfg_legacy_cpu;
    logic              flush;
    logic              busy;
    logic              res_valid;
    logic              res_hit;
    logic [CNT_W-1:0]  rd_miss_cnt;
    logic [CNT_W-1:0]  wr_miss_cnt;
    logic [PEN_W-1:0]  penalty_total;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    page_presence_tracker #(
        .ADDR_W   (ADDR_W),
        .MAP_BITS (MAP_B),
        .MULT_W   (MULT_W),
        .CNT_W    (CNT_W),
        .PEN_W    (PEN_W)
    ) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .lookup_valid   (lookup_valid),
        .lookup_write   (lookup_write),
        .lookup_addr    (lookup_addr),
        .cfg_cache_sel  (cfg_cache_sel),
        .cfg_bus16      (cfg_bus16),
        .cfg_mult       (cfg_mult),
        .cfg_legacy_cpu (cfg_legacy_cpu),
        .flush          (flush),
        .busy           (busy),
        .res_valid      (res_valid),
        .res_hit        (res_hit),
        .rd_miss_cnt    (rd_miss_cnt),
        .wr_miss_cnt    (wr_miss_cnt),
        .penalty_total  (penalty_total)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One lookup; result checked one cycle later at the falling edge.
    task automatic lookup(input int page, input bit wr, input bit exp_hit,
                          input int ofs, input string req);
        lookup_addr  = (ADDR_W'(page) << 12) | ADDR_W'(ofs & 12'hfff);
        lookup_write = wr;
        lookup_valid = 1'b1;
        @(negedge clk);
        lookup_valid = 1'b0;
        check(res_valid === 1'b1 && res_hit === exp_hit, req,
              {res_valid, res_hit}, {1'b1, exp_hit});
    endtask

    // Flush; counts busy cycles, optionally probes a lookup while busy.
    task automatic do_flush(input bit probe);
        int n = 0;
        bit leak = 0;
        logic [CNT_W-1:0] rd0, wr0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        rd0 = rd_miss_cnt;
        wr0 = wr_miss_cnt;
        while (busy === 1'b1 && n < 1000) begin
            if (res_valid === 1'b1) leak = 1;
            lookup_addr  = ADDR_W'(5) << 12;
            lookup_write = 1'b0;
            lookup_valid = probe && (n == 2);
            n++;
            @(negedge clk);
        end
        lookup_valid = 1'b0;
        check(n == 256, "R9 busy length", n, 256);
        if (probe) begin
            check(!leak && res_valid === 1'b0, "R9 lookup during busy dropped", leak, 0);
            check(rd_miss_cnt == rd0 && wr_miss_cnt == wr0, "R9 counters held during busy",
                  rd_miss_cnt, rd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        lookup_valid = 1'b0;
        lookup_write = 1'b0;
        lookup_addr = '0;
        cfg_cache_sel = 3'd0;
        cfg_bus16 = 1'b0;
        cfg_mult = 3'd1;
        cfg_legacy_cpu = 1'b0;
        flush = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(res_valid === 1'b0 && busy === 1'b0, "R1 res_valid/busy", {res_valid, busy}, 0);
        check(rd_miss_cnt == 0 && wr_miss_cnt == 0 && penalty_total == 0,
              "R1 counters", rd_miss_cnt + wr_miss_cnt + penalty_total, 0);

        // R3 fill 32 pages (depth 32), then R2 hit at other offsets
        for (int p = 0; p < 32; p++) lookup(p, 1'b0, 1'b0, p * 52, "R3 first access misses");
        for (int p = 0; p < 32; p++) lookup(p, 1'b0, 1'b1, 12'hfff - p, "R2 same page other offset hits");
        check(rd_miss_cnt == 32 && wr_miss_cnt == 0, "R6 read misses", rd_miss_cnt, 32);
        check(penalty_total == 32 * 384, "R7 penalty wide x1", penalty_total, 32 * 384);

        // R5 FIFO eviction order
        lookup(32, 1'b1, 1'b0, 0, "R5 write miss evicts slot 0");
        check(wr_miss_cnt == 1, "R6 write miss counted", wr_miss_cnt, 1);
        lookup(1, 1'b0, 1'b1, 0, "R5 page 1 still resident");
        lookup(0, 1'b0, 1'b0, 0, "R5 oldest page evicted");
        lookup(1, 1'b0, 1'b0, 0, "R5 next oldest evicted by refill");
        // R2 alias above MAP_BITS: page 3+512 shares page 3's bit
        lookup(3 + 512, 1'b0, 1'b1, 0, "R2 high page bits ignored");
        lookup(2, 1'b0, 1'b0, 0, "R5 page 2 evicted");
        check(rd_miss_cnt == 35 && wr_miss_cnt == 1, "R6 split counts", rd_miss_cnt, 35);
        check(penalty_total == 36 * 384, "R7 penalty total", penalty_total, 36 * 384);

        // R9 flush with a dropped probe, then everything misses
        do_flush(1'b1);
        lookup(5, 1'b0, 1'b0, 0, "R9 flushed page misses");
        lookup(32, 1'b0, 1'b0, 0, "R9 flushed page misses");

        // R4 R7 R8 sweep
        for (int sel = 0; sel < 5; sel++)
        for (int leg = 0; leg < 2; leg++)
        for (int b16 = 0; b16 < 2; b16++)
        for (int m = 0; m < 4; m++) begin
            int size, step, base;
            bit wr;
            logic [CNT_W-1:0] rd0, wr0;
            logic [PEN_W-1:0] pen0;
            cfg_cache_sel = 3'(sel);
            cfg_legacy_cpu = leg[0];
            cfg_bus16 = b16[0];
            cfg_mult = 3'(m);
            size = (leg != 0 || sel >= 3) ? 256 : (32 << sel);
            step = (leg != 0 || sel == 4) ? 0 : (b16 != 0 ? 512 : 384) * (m > 2 ? 2 : m);
            base = sel * 37;
            wr = m[0];
            do_flush(1'b0);
            rd0 = rd_miss_cnt;
            wr0 = wr_miss_cnt;
            pen0 = penalty_total;
            for (int p = 0; p < size; p++) lookup(base + p, wr, 1'b0, p, "R4 fill misses");
            lookup(base, 1'b0, 1'b1, 8, "R4 oldest kept at depth");
            lookup(base + size, 1'b0, 1'b0, 8, "R4 one past depth misses");
            lookup(base, 1'b0, 1'b0, 8, "R4 oldest evicted past depth");
            check(rd_miss_cnt - rd0 == CNT_W'((wr ? 0 : size) + 2), "R6 read delta",
                  rd_miss_cnt - rd0, (wr ? 0 : size) + 2);
            check(wr_miss_cnt - wr0 == CNT_W'(wr ? size : 0), "R6 write delta",
                  wr_miss_cnt - wr0, wr ? size : 0);
            check(penalty_total - pen0 == PEN_W'((size + 2) * step), "R7 R8 penalty delta",
                  penalty_total - pen0, (size + 2) * step);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule